// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

An 8-bit up-counter that advances either once per instruction cycle or on rising edges of an external input pin. An optional power-of-two prescaler can sit in front of the counter. The input clock is split into four quarter-phases, Q1 to Q4, by a free-running 2-bit phase counter. One instruction cycle is therefore four clocks, and internal counting happens at the Q4 boundary.

External edges pass through a synchronizer. The prescaler output, or the synchronized pin when the prescaler is bypassed, is then sampled at Q2 and at Q4.

Software can load the count through a write strobe. Every load silently restarts the hidden prescaler. The count can be frozen with a sleep input. Each wrap from 8'hFF to 8'h00 raises a sticky overflow flag that only a clear strobe removes. The interrupt output is that flag qualified by an enable bit.

Top module: `tmr8_prescaled`

## Requirements
- R1: After reset the count, the overflow flag and the interrupt output are all 0.
- R2: With the internal source and the prescaler bypassed (`cfg_bypass`=1), the count rises by exactly 1 per instruction cycle, that is once every 4 clocks, at the Q4 boundary.
- R3: With the prescaler active (`cfg_bypass`=0), the 3-bit select field `cfg_ps_sel` gives a ratio of 2^(sel+1): 000 is 1:2 and 111 is 1:256. The prescaler counts source events from zero. The timer advances when bit `sel` of the prescaler goes from 0 to 1. After E events the timer has therefore advanced floor((E + 2^sel) / 2^(sel+1)) times.
- R4: A write (`cnt_wr`=1) loads `cnt_wdata` on the next edge and clears the prescaler. It takes priority over an increment in the same cycle. The next two Q4 boundaries after the write produce no increment and no prescaler advance.
- R5: With the external source (`cfg_ext`=1), the pin goes through a two-stage synchronizer. The prescaler then counts rising edges of the synchronized pin. The timer advances on each 0-to-1 change between successive Q2/Q4 samples of the prescaler bit `sel`, or of the synchronized pin when the prescaler is bypassed.
- R6: Every increment from 8'hFF to 8'h00 sets `ovf_flag`, whatever the value of `cfg_irq_en`. `irq` is high exactly when `ovf_flag` and `cfg_irq_en` are both 1.
- R7: `ovf_flag` stays set until `ovf_clr` is pulsed while not asleep. A wrap in the same cycle as a clear wins, and hardware never clears the flag.
- R8: While `sleep_req`=1, the count, the flag and the prescaler hold their values, and `ovf_clr` has no effect. A write still loads the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (four clocks per instruction cycle) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_wr | input | 1 | Count register write strobe |
| cnt_wdata | input | 8 | Value loaded on a write |
| cfg_ext | input | 1 | 1: count external pin edges, 0: count instruction cycles |
| cfg_bypass | input | 1 | 1: prescaler bypassed (1:1), 0: prescaler in use |
| cfg_ps_sel | input | 3 | Prescale select, ratio 2^(sel+1) |
| cfg_irq_en | input | 1 | Overflow interrupt enable |
| ext_pin | input | 1 | Asynchronous external count input |
| sleep_req | input | 1 | Freeze request |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| cnt_value | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Qualified overflow interrupt |

## Verification
The bench sweeps every prescale select in both source modes, plus the bypass setting. It compares the count against the closed-form rise count. A prescaler that divided by 2^sel, or by 2^(sel+1) counted from the wrong phase, would be off by one increment or by a factor of two.

Loads are checked at the two-Q4 inhibit boundary, so a design that resumed one cycle early, or kept a stale prescaler residue, would be caught. The bench starts each count just below 8'hFF, so a missed or doubled wrap shows up in the flag.

Sleep is checked both for a frozen count and for an ignored clear. The interrupt output is checked with the flag set and the enable in both states.

// File: rtl/tmr8_pkg.sv
`timescale 1ns/1ps
package tmr8_pkg;
  localparam int SEL_W = 3;
  localparam int PS_W  = 1 << SEL_W;
  localparam int CNT_W = 8;

  typedef enum logic [1:0] {PH_Q1 = 2'd0, PH_Q2 = 2'd1, PH_Q3 = 2'd2, PH_Q4 = 2'd3} phase_t;

  // Selected prescaler bit goes 0 -> 1 on the next advance
  function automatic logic tap_edge(input logic [PS_W-1:0] cur, input logic [SEL_W-1:0] sel);
    logic [PS_W-1:0] nxt;
    nxt = cur + PS_W'(1);
    return (!cur[sel]) && nxt[sel];
  endfunction

  // Count sits at its maximum, so the next increment wraps
  function automatic logic at_top(input logic [CNT_W-1:0] v);
    return &v;
  endfunction
endpackage

// File: rtl/tmr8_phase_gen.sv
`timescale 1ns/1ps
module tmr8_phase_gen
  import tmr8_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic q2_evt,
  output logic q4_evt
);
  phase_t ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_Q1;
    else        ph <= phase_t'(ph + 2'd1);
  end

  assign q2_evt = (ph == PH_Q2);
  assign q4_evt = (ph == PH_Q4);
endmodule

// File: rtl/tmr8_ext_sync.sv
`timescale 1ns/1ps
module tmr8_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pin_s,
  output logic pin_rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= chain[STAGES-1];
    end
  end

  assign pin_s    = chain[STAGES-1];
  assign pin_rise = pin_s & ~prev;
endmodule

// File: rtl/tmr8_prescaler.sv
`timescale 1ns/1ps
module tmr8_prescaler
  import tmr8_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [SEL_W-1:0] sel,
  output logic             tap_level,
  output logic             tap_rise
);
  logic [PS_W-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pcnt <= '0;
    else if (clr) pcnt <= '0;
    else if (adv) pcnt <= pcnt + PS_W'(1);
  end

  assign tap_level = pcnt[sel];
  assign tap_rise  = adv & ~clr & tap_edge(pcnt, sel);
endmodule

// File: rtl/tmr8_count_core.sv
`timescale 1ns/1ps
module tmr8_count_core
  import tmr8_pkg::*;
#(
  parameter int INH_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             inc_ok,
  input  logic             q4_evt,
  input  logic             frozen,
  input  logic             clr_req,
  output logic [CNT_W-1:0] cnt,
  output logic             flag,
  output logic             inh_active,
  output logic             wrap_evt
);
  localparam int INH_W = $clog2(INH_CYC + 1);
  logic [INH_W-1:0] inh;

  assign wrap_evt   = inc_ok & at_top(cnt);
  assign inh_active = (inh != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (wr)     cnt <= wdata;
    else if (inc_ok) cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          inh <= '0;
    else if (wr)                         inh <= INH_W'(INH_CYC);
    else if (q4_evt && inh_active && !frozen) inh <= inh - INH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  flag <= 1'b0;
    else if (wrap_evt)           flag <= 1'b1;
    else if (clr_req && !frozen) flag <= 1'b0;
  end
endmodule

// File: rtl/tmr8_prescaled.sv
`timescale 1ns/1ps
module tmr8_prescaled
  import tmr8_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int INH_CYC     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cfg_ext,
  input  logic             cfg_bypass,
  input  logic [SEL_W-1:0] cfg_ps_sel,
  input  logic             cfg_irq_en,
  input  logic             ext_pin,
  input  logic             sleep_req,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt_value,
  output logic             ovf_flag,
  output logic             irq
);
  logic q2_evt, q4_evt;
  logic pin_s, pin_rise;
  logic tap_level, tap_rise;
  logic inh_active, wrap_evt;
  logic pre_adv, samp_src, samp_q, samp_evt;
  logic int_inc, ext_inc, inc_ok;

  tmr8_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n), .q2_evt(q2_evt), .q4_evt(q4_evt)
  );

  tmr8_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .pin_s(pin_s), .pin_rise(pin_rise)
  );

  assign pre_adv = ~sleep_req & ~inh_active & ~cnt_wr & ~cfg_bypass &
                   (cfg_ext ? pin_rise : q4_evt);

  tmr8_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .clr(cnt_wr), .adv(pre_adv), .sel(cfg_ps_sel),
    .tap_level(tap_level), .tap_rise(tap_rise)
  );

  // External path: quarter-phase sampling of prescaler bit or pin
  assign samp_evt = q2_evt | q4_evt;
  assign samp_src = cfg_bypass ? pin_s : tap_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      samp_q <= 1'b0;
    else if (samp_evt && !sleep_req) samp_q <= samp_src;
  end

  assign ext_inc = samp_evt & samp_src & ~samp_q;
  assign int_inc = cfg_bypass ? q4_evt : tap_rise;
  assign inc_ok  = (cfg_ext ? ext_inc : int_inc) & ~sleep_req & ~inh_active & ~cnt_wr;

  tmr8_count_core #(.INH_CYC(INH_CYC)) u_core (
    .clk(clk), .rst_n(rst_n), .wr(cnt_wr), .wdata(cnt_wdata), .inc_ok(inc_ok),
    .q4_evt(q4_evt), .frozen(sleep_req), .clr_req(ovf_clr),
    .cnt(cnt_value), .flag(ovf_flag), .inh_active(inh_active), .wrap_evt(wrap_evt)
  );

  assign irq = ovf_flag & cfg_irq_en;
endmodule

// File: rtl/tmr8_checker.sv
`timescale 1ns/1ps
module tmr8_checker
  import tmr8_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cnt_value,
  input logic             sleep_req,
  input logic             ovf_flag,
  input logic             ovf_clr,
  input logic             wrap_evt,
  input logic             inh_active,
  input logic             q2_evt,
  input logic             q4_evt
);
  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt_value == $past(cnt_value)) || (cnt_value == $past(cnt_value) + CNT_W'(1)));

  // R4
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_value == $past(cnt_wdata));

  // R4
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> inh_active);

  // R8
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req && !cnt_wr |=> $stable(cnt_value) && $stable(ovf_flag));

  // R6
  wrap_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_flag && cnt_value == '0);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(ovf_clr) && !$past(sleep_req));

  // R5
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({q2_evt, q4_evt}));
endmodule

bind tmr8_prescaled tmr8_checker chk_i (
  .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
  .cnt_value(cnt_value), .sleep_req(sleep_req), .ovf_flag(ovf_flag),
  .ovf_clr(ovf_clr), .wrap_evt(wrap_evt), .inh_active(inh_active),
  .q2_evt(q2_evt), .q4_evt(q4_evt)
);

// File: tb/tmr8_prescaled_tb_top.sv
`timescale 1ns/1ps
module tmr8_prescaled_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_wr = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic       cfg_ext = 1'b0;
  logic       cfg_bypass = 1'b1;
  logic [2:0] cfg_ps_sel = '0;
  logic       cfg_irq_en = 1'b0;
  logic       ext_pin = 1'b0;
  logic       sleep_req = 1'b0;
  logic       ovf_clr = 1'b0;
  logic [7:0] cnt_value;
  logic       ovf_flag;
  logic       irq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int q4n = 0;
  int base = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr8_prescaled dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cfg_ext(cfg_ext), .cfg_bypass(cfg_bypass), .cfg_ps_sel(cfg_ps_sel),
    .cfg_irq_en(cfg_irq_en), .ext_pin(ext_pin), .sleep_req(sleep_req),
    .ovf_clr(ovf_clr), .cnt_value(cnt_value), .ovf_flag(ovf_flag), .irq(irq)
  );

  // Bench's own view of the quarter-phases: edge n after reset is Q4 when n%4==0
  always @(posedge clk) begin
    if (rst_n) begin
      cyc = cyc + 1;
      if (cyc % 4 == 0) q4n = q4n + 1;
    end
  end

  function automatic int rises(input int e, input int sel);
    return (e + (1 << sel)) >> (sel + 1);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk);
    cnt_wr = 1'b1; cnt_wdata = v; ovf_clr = 1'b1;
    @(posedge clk); #1;
    base = q4n;
    @(negedge clk);
    cnt_wr = 1'b0; ovf_clr = 1'b0;
  endtask

  task automatic run_int(input bit byp, input int sel, input logic [7:0] v);
    int k, d, e, n;
    @(negedge clk);
    cfg_ext = 1'b0; cfg_bypass = byp; cfg_ps_sel = 3'(sel);
    load(v);
    k = byp ? 40 : 4 * (2 + 3 * (2 << sel)) + 6;
    wait_clk(k);
    d = q4n - base;
    e = (d > 2) ? d - 2 : 0;
    n = byp ? e : rises(e, sel);
    if (byp) chk("R2 internal bypass count", int'(cnt_value), (int'(v) + n) % 256);
    else     chk($sformatf("R3 internal sel=%0d count", sel), int'(cnt_value), (int'(v) + n) % 256);
    chk("R6 flag after internal run", int'(ovf_flag), (int'(v) + n >= 256) ? 1 : 0);
  endtask

  task automatic pulse_pin(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_pin = 1'b1;
      wait_clk(8);
      ext_pin = 1'b0;
      wait_clk(7);
    end
  endtask

  task automatic run_ext(input bit byp, input int sel, input logic [7:0] v, input int np);
    int n;
    @(negedge clk);
    cfg_ext = 1'b1; cfg_bypass = byp; cfg_ps_sel = 3'(sel);
    load(v);
    wait_clk(20);
    pulse_pin(np);
    wait_clk(10);
    n = byp ? np : rises(np, sel);
    chk($sformatf("R5 external byp=%0d sel=%0d count", byp, sel), int'(cnt_value), (int'(v) + n) % 256);
    chk("R6 flag after external run", int'(ovf_flag), (int'(v) + n >= 256) ? 1 : 0);
  endtask

  initial begin
    int snap;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(1);
    // R1
    chk("R1 reset count", int'(cnt_value), 0);
    chk("R1 reset flag", int'(ovf_flag), 0);
    chk("R1 reset irq", int'(irq), 0);

    // R2 and R3: internal source sweep
    run_int(1'b1, 0, 8'hFE);
    for (int s = 0; s < 8; s++) run_int(1'b0, s, 8'hFE);

    // R5: external source
    run_ext(1'b1, 0, 8'hFD, 5);
    for (int s = 0; s < 4; s++) run_ext(1'b0, s, 8'hFD, 5);
    run_ext(1'b0, 7, 8'hFF, 128);

    // R4: load, priority and two-Q4 inhibit
    @(negedge clk);
    cfg_ext = 1'b0; cfg_bypass = 1'b1;
    load(8'h40);
    chk("R4 loaded value", int'(cnt_value), 8'h40);
    while (q4n - base < 2) @(negedge clk);
    chk("R4 held through inhibit", int'(cnt_value), 8'h40);
    while (q4n - base < 3) @(negedge clk);
    chk("R4 first increment after inhibit", int'(cnt_value), 8'h41);

    // R4: a load clears prescaler residue
    @(negedge clk);
    cfg_bypass = 1'b0; cfg_ps_sel = 3'd2;
    wait_clk(30);
    load(8'h10);
    wait_clk(4 * (2 + 4) + 2);
    chk("R4 prescaler restarted by load", int'(cnt_value), 8'h10 + rises(q4n - base - 2, 2));

    // R8: sleep freezes the count
    @(negedge clk);
    cfg_bypass = 1'b1;
    load(8'h20);
    wait_clk(20);
    sleep_req = 1'b1;
    snap = int'(cnt_value);
    wait_clk(40);
    chk("R8 count frozen in sleep", int'(cnt_value), snap);
    sleep_req = 1'b0;
    wait_clk(8);
    chk("R8 resumes after sleep", int'(cnt_value), snap + 2);

    // R6 and R7: flag, enable, clear
    load(8'hFC);
    wait_clk(40);
    chk("R6 flag set with enable low", int'(ovf_flag), 1);
    chk("R6 irq low while disabled", int'(irq), 0);
    cfg_irq_en = 1'b1;
    wait_clk(1);
    chk("R6 irq high when enabled", int'(irq), 1);
    wait_clk(60);
    chk("R7 flag persists without clear", int'(ovf_flag), 1);
    sleep_req = 1'b1;
    ovf_clr = 1'b1;
    wait_clk(1);
    ovf_clr = 1'b0;
    wait_clk(1);
    chk("R8 clear ignored in sleep", int'(ovf_flag), 1);
    sleep_req = 1'b0;
    ovf_clr = 1'b1;
    wait_clk(1);
    ovf_clr = 1'b0;
    chk("R7 clear strobe drops flag", int'(ovf_flag), 0);
    chk("R6 irq follows cleared flag", int'(irq), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule